// File: doc/BRIEF.md
# Banked Memory Self-Test Coordinator

This block sits at chip level between the test controls and a set of memory self-test engines. It fans the global start, reset and fault-map controls out to every engine, passes a per-memory hold line to each one, merges the engines' completion and error flags into one chip-level pair, and chooses which engine's diagnostic word reaches the shared diagnostic output.

Engines are grouped into banks that run one after another to cap peak power. The global start launches the first bank only; each later bank is started automatically once every engine of the bank before it reports completion, and the chip-level completion flag follows the last bank. When the test-enable input is low, every control sent to the engines is held at 0 and every chip-level result is forced to 0, so nothing from the self-test logic reaches the pins.

Top module: `mbist_bank_ctrl`

## Requirements
- R1: While test_en_i is 1, unit_reset_o and unit_bitmap_o carry g_reset_i and g_bitmap_i to every unit in the same cycle.
- R2: From idle, g_invoke_i high at a clock edge raises unit_invoke_o for the units of bank 0 (unit indices 0 to UNITS_PER_BANK-1) from the next cycle; units of later banks stay uninvoked.
- R3: bank_done_o[b] is 1 exactly when test_en_i is 1 and every unit of bank b (indices b*UNITS_PER_BANK upward) reports done.
- R4: The cycle after bank b is all done, the units of bank b+1 are invoked; units of earlier banks stay invoked, so a unit of bank b+1 is never invoked while one of bank b is not.
- R5: chip_done_o rises the cycle after the last bank is all done, is 0 before that, and stays 1 until global reset or test disable.
- R6: chip_fail_o is 1 exactly when test_en_i is 1 and any unit_fail_i bit is 1.
- R7: unit_hold_o equals hold_i while test_en_i is 1.
- R8: With test enabled and g_bitmap_i 1, chip_diag_o is the DIAG_W-bit slice (unit u at bits u*DIAG_W upward) of the lowest-numbered unit whose hold_i bit is 0; it is 0 when all units are held or g_bitmap_i is 0.
- R9: With test_en_i 0, every unit_* output, bank_done_o, chip_done_o, chip_fail_o and chip_diag_o is 0, and the sequencer returns to idle.
- R10: g_reset_i high at a clock edge returns the sequencer to idle: from the next cycle no unit is invoked and chip_done_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| test_en_i | input | 1 | Self-test enabled |
| g_invoke_i | input | 1 | Global start |
| g_reset_i | input | 1 | Global self-test reset |
| g_bitmap_i | input | 1 | Global fault-map (debug) mode |
| hold_i | input | NUM_UNITS | Per-unit hold: retention pause or diagnostic deselect |
| unit_done_i | input | NUM_UNITS | Per-unit completion |
| unit_fail_i | input | NUM_UNITS | Per-unit error |
| unit_diag_i | input | NUM_UNITS*DIAG_W | Per-unit diagnostic words |
| unit_invoke_o | output | NUM_UNITS | Per-unit start |
| unit_reset_o | output | NUM_UNITS | Per-unit reset |
| unit_bitmap_o | output | NUM_UNITS | Per-unit fault-map mode |
| unit_hold_o | output | NUM_UNITS | Per-unit hold |
| bank_done_o | output | NUM_BANKS | Per-bank completion |
| chip_done_o | output | 1 | All banks complete |
| chip_fail_o | output | 1 | Any unit failed |
| chip_diag_o | output | DIAG_W | Selected diagnostic word |

## Verification
The assertions watch on every cycle that disabled test keeps all outputs quiet, that a later bank is never invoked ahead of its predecessor, that the merged error flag tracks the unit flags, that completion rises only after the last bank finished, and that a global reset clears all invocations. Only the bench scenarios show the full sequence against modelled engines with differing run times: bank 0 alone starting, the hand-over to bank 1, the priority of the diagnostic selection under several hold patterns, and the return to idle after reset.

// File: rtl/mbist_pkg.sv
// Shared types for the banked self-test coordinator.
package mbist_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mbist_bank_seq.sv
// Bank sequencer: starts bank 0 on start, advances one bank each time the
// current bank reports done, and parks in FIN after the last bank.
// Assumes bank_done_i is already gated by test enable.
module mbist_bank_seq #(
    parameter int NUM_BANKS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 start_i,
    input  logic                 clear_i,
    input  logic [NUM_BANKS-1:0] bank_done_i,
    output logic [NUM_BANKS-1:0] bank_run_o,
    output logic                 all_done_o
);
    import mbist_pkg::*;

    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    seq_state_t        state_q;
    logic [BANK_W-1:0] cur_q;

    // State and current-bank register with enable/clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || clear_i) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: if (start_i) begin
                    state_q <= SEQ_RUN;
                    cur_q   <= '0;
                end
                SEQ_RUN: if (bank_done_i[cur_q]) begin
                    if (cur_q == LAST_BANK) state_q <= SEQ_FIN;
                    else                    cur_q   <= cur_q + 1'b1;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Banks up to and including the current one stay invoked.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_run
        assign bank_run_o[b] = (state_q == SEQ_FIN) ||
                               ((state_q == SEQ_RUN) && (cur_q >= BANK_W'(b)));
    end

    assign all_done_o = (state_q == SEQ_FIN);
endmodule

// File: rtl/mbist_status_merge.sv
// Status merge: per-bank AND of unit done flags, global OR of unit fails.
// Assumes units of bank b occupy indices b*UNITS_PER_BANK upward.
module mbist_status_merge #(
    parameter int NUM_BANKS      = 2,
    parameter int UNITS_PER_BANK = 2,
    localparam int NUM_UNITS     = NUM_BANKS * UNITS_PER_BANK
) (
    input  logic [NUM_UNITS-1:0] done_i,
    input  logic [NUM_UNITS-1:0] fail_i,
    output logic [NUM_BANKS-1:0] bank_done_o,
    output logic                 any_fail_o
);
    // One AND reduction per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_done_o[b] = &done_i[b*UNITS_PER_BANK +: UNITS_PER_BANK];
    end

    assign any_fail_o = |fail_i;
endmodule

// File: rtl/mbist_diag_sel.sv
// Diagnostic selector: picks the word of the lowest-numbered unheld unit.
// Returns zero when every unit is held.
module mbist_diag_sel #(
    parameter int NUM_UNITS = 4,
    parameter int DIAG_W    = 4
) (
    input  logic [NUM_UNITS-1:0]        hold_i,
    input  logic [NUM_UNITS*DIAG_W-1:0] diag_i,
    output logic [DIAG_W-1:0]           diag_o
);
    // Scan from the top so the lowest unheld index wins.
    always_comb begin
        diag_o = '0;
        for (int i = NUM_UNITS - 1; i >= 0; i--) begin
            if (!hold_i[i]) diag_o = diag_i[i*DIAG_W +: DIAG_W];
        end
    end
endmodule

// File: rtl/mbist_bank_ctrl.sv
// Top: distributes global self-test controls, sequences banks, merges status
// and selects diagnostics; everything is gated to 0 when test is disabled.
// Assumes units are numbered bank by bank.
module mbist_bank_ctrl #(
    parameter int NUM_BANKS      = 2,
    parameter int UNITS_PER_BANK = 2,
    parameter int DIAG_W         = 4,
    localparam int NUM_UNITS     = NUM_BANKS * UNITS_PER_BANK
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        test_en_i,
    input  logic                        g_invoke_i,
    input  logic                        g_reset_i,
    input  logic                        g_bitmap_i,
    input  logic [NUM_UNITS-1:0]        hold_i,
    input  logic [NUM_UNITS-1:0]        unit_done_i,
    input  logic [NUM_UNITS-1:0]        unit_fail_i,
    input  logic [NUM_UNITS*DIAG_W-1:0] unit_diag_i,
    output logic [NUM_UNITS-1:0]        unit_invoke_o,
    output logic [NUM_UNITS-1:0]        unit_reset_o,
    output logic [NUM_UNITS-1:0]        unit_bitmap_o,
    output logic [NUM_UNITS-1:0]        unit_hold_o,
    output logic [NUM_BANKS-1:0]        bank_done_o,
    output logic                        chip_done_o,
    output logic                        chip_fail_o,
    output logic [DIAG_W-1:0]           chip_diag_o
);
    logic [NUM_BANKS-1:0] bank_run;
    logic [NUM_BANKS-1:0] bank_done_raw;
    logic                 all_done;
    logic                 any_fail;
    logic [DIAG_W-1:0]    diag_sel;

    mbist_status_merge #(
        .NUM_BANKS      (NUM_BANKS),
        .UNITS_PER_BANK (UNITS_PER_BANK)
    ) u_merge (
        .done_i      (unit_done_i),
        .fail_i      (unit_fail_i),
        .bank_done_o (bank_done_raw),
        .any_fail_o  (any_fail)
    );

    mbist_bank_seq #(
        .NUM_BANKS (NUM_BANKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (test_en_i),
        .start_i     (g_invoke_i),
        .clear_i     (g_reset_i),
        .bank_done_i (bank_done_o),
        .bank_run_o  (bank_run),
        .all_done_o  (all_done)
    );

    mbist_diag_sel #(
        .NUM_UNITS (NUM_UNITS),
        .DIAG_W    (DIAG_W)
    ) u_diag (
        .hold_i (hold_i),
        .diag_i (unit_diag_i),
        .diag_o (diag_sel)
    );

    // Per-unit control fan-out, gated by test enable.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign unit_invoke_o[u] = test_en_i & bank_run[u / UNITS_PER_BANK];
        assign unit_reset_o[u]  = test_en_i & g_reset_i;
        assign unit_bitmap_o[u] = test_en_i & g_bitmap_i;
        assign unit_hold_o[u]   = test_en_i & hold_i[u];
    end

    // Chip-level results, blocked from the pins when test is off.
    assign bank_done_o = test_en_i ? bank_done_raw : '0;
    assign chip_done_o = test_en_i & all_done;
    assign chip_fail_o = test_en_i & any_fail;
    assign chip_diag_o = (test_en_i && g_bitmap_i) ? diag_sel : '0;
endmodule

// File: rtl/mbist_bank_ctrl_chk.sv
// Checker bound to the coordinator top; observes ports only.
module mbist_bank_ctrl_chk #(
    parameter int NUM_BANKS      = 2,
    parameter int UNITS_PER_BANK = 2,
    parameter int DIAG_W         = 4,
    localparam int NUM_UNITS     = NUM_BANKS * UNITS_PER_BANK
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        test_en_i,
    input logic                        g_invoke_i,
    input logic                        g_reset_i,
    input logic                        g_bitmap_i,
    input logic [NUM_UNITS-1:0]        hold_i,
    input logic [NUM_UNITS-1:0]        unit_done_i,
    input logic [NUM_UNITS-1:0]        unit_fail_i,
    input logic [NUM_UNITS*DIAG_W-1:0] unit_diag_i,
    input logic [NUM_UNITS-1:0]        unit_invoke_o,
    input logic [NUM_UNITS-1:0]        unit_reset_o,
    input logic [NUM_UNITS-1:0]        unit_bitmap_o,
    input logic [NUM_UNITS-1:0]        unit_hold_o,
    input logic [NUM_BANKS-1:0]        bank_done_o,
    input logic                        chip_done_o,
    input logic                        chip_fail_o,
    input logic [DIAG_W-1:0]           chip_diag_o
);
    localparam int LAST_LO = (NUM_BANKS - 1) * UNITS_PER_BANK;

    p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en_i |-> (unit_invoke_o == '0 && unit_reset_o == '0 &&
                        unit_bitmap_o == '0 && unit_hold_o == '0 &&
                        !chip_done_o && !chip_fail_o && chip_diag_o == '0));

    for (genvar u = UNITS_PER_BANK; u < NUM_UNITS; u++) begin : g_ord
        p_bank_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
            unit_invoke_o[u] |-> unit_invoke_o[u - UNITS_PER_BANK]);
    end

    p_fail_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chip_fail_o == (test_en_i && (unit_fail_i != '0)));

    p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_done_o) |-> $past(&unit_done_i[LAST_LO +: UNITS_PER_BANK]));

    p_reset_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en_i && g_reset_i) |=> (unit_invoke_o == '0 && !chip_done_o));

    p_diag_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !g_bitmap_i |-> chip_diag_o == '0);
endmodule

bind mbist_bank_ctrl mbist_bank_ctrl_chk #(
    .NUM_BANKS      (NUM_BANKS),
    .UNITS_PER_BANK (UNITS_PER_BANK),
    .DIAG_W         (DIAG_W)
) u_chk (.*);

// File: tb/tb_mbist_bank_ctrl.sv
module tb_mbist_bank_ctrl;
    localparam int NB = 2;
    localparam int UPB = 2;
    localparam int DW = 4;
    localparam int NU = NB * UPB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0, g_inv = 1'b0, g_rst = 1'b0, g_bmp = 1'b0;
    logic [NU-1:0] hold = '0;
    logic [NU-1:0] u_done, u_fail;
    logic [NU*DW-1:0] u_diag;
    logic [NU-1:0] inv_o, rst_o, bmp_o, hold_o;
    logic [NB-1:0] bdone_o;
    logic cdone_o, cfail_o;
    logic [DW-1:0] diag_o;

    logic [NU-1:0] fail_inject = '0;
    logic [NU-1:0] fail_force = '0;
    int cnt [NU];
    int lat [NU] = '{3, 5, 4, 2};

    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    mbist_bank_ctrl #(.NUM_BANKS(NB), .UNITS_PER_BANK(UPB), .DIAG_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .test_en_i(test_en), .g_invoke_i(g_inv),
        .g_reset_i(g_rst), .g_bitmap_i(g_bmp), .hold_i(hold),
        .unit_done_i(u_done), .unit_fail_i(u_fail), .unit_diag_i(u_diag),
        .unit_invoke_o(inv_o), .unit_reset_o(rst_o), .unit_bitmap_o(bmp_o),
        .unit_hold_o(hold_o), .bank_done_o(bdone_o), .chip_done_o(cdone_o),
        .chip_fail_o(cfail_o), .chip_diag_o(diag_o));

    // Behavioural self-test engines: count while invoked, done at latency.
    for (genvar u = 0; u < NU; u++) begin : g_model
        always_ff @(posedge clk) begin
            if (!inv_o[u] || rst_o[u]) cnt[u] <= 0;
            else if (cnt[u] < lat[u])  cnt[u] <= cnt[u] + 1;
        end
        assign u_done[u] = (cnt[u] == lat[u]);
        assign u_fail[u] = (u_done[u] & fail_inject[u]) | fail_force[u];
        assign u_diag[u*DW +: DW] = DW'(4'hA ^ u);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_bank(input int b);
        for (int i = 0; i < 30; i++) begin
            if (bdone_o[b]) break;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        check("R9 reset invoke", 32'(inv_o), 0);
        check("R9 reset done", 32'(cdone_o), 0);
    endtask

    task automatic t_full_run();
        @(negedge clk); test_en = 1; g_inv = 1;
        @(negedge clk);
        check("R2 bank0 invoked", 32'(inv_o), 32'b0011);
        g_inv = 0;
        wait_bank(0);
        check("R3 bank0 done only", 32'(bdone_o), 32'b01);
        check("R4 bank1 not yet", 32'(inv_o), 32'b0011);
        @(negedge clk);
        check("R4 bank1 invoked", 32'(inv_o), 32'b1111);
        check("R5 not done early", 32'(cdone_o), 0);
        wait_bank(1);
        check("R3 both banks", 32'(bdone_o), 32'b11);
        check("R5 done lags", 32'(cdone_o), 0);
        @(negedge clk);
        check("R5 chip done", 32'(cdone_o), 1);
        check("R6 no fail", 32'(cfail_o), 0);
        @(negedge clk); @(negedge clk);
        check("R5 done held", 32'(cdone_o), 1);
    endtask

    task automatic t_global_reset();
        @(negedge clk); g_rst = 1;
        #1 check("R1 reset fanout", 32'(rst_o), 32'b1111);
        @(negedge clk); g_rst = 0;
        check("R10 invokes cleared", 32'(inv_o), 0);
        check("R10 done cleared", 32'(cdone_o), 0);
    endtask

    task automatic t_fail_run();
        fail_inject = 4'b1000;
        @(negedge clk); g_inv = 1;
        @(negedge clk); g_inv = 0;
        wait_bank(0);
        check("R6 fail quiet", 32'(cfail_o), 0);
        @(negedge clk);
        wait_bank(1);
        check("R6 fail merged", 32'(cfail_o), 1);
        fail_inject = '0;
        @(negedge clk); g_rst = 1; @(negedge clk); g_rst = 0;
    endtask

    task automatic t_diag();
        @(negedge clk); g_bmp = 1; hold = 4'b0011;
        #1 check("R1 bitmap fanout", 32'(bmp_o), 32'b1111);
        check("R7 hold pass", 32'(hold_o), 32'b0011);
        check("R8 lowest unheld 2", 32'(diag_o), 32'(4'hA ^ 2));
        hold = 4'b0000;
        #1 check("R8 lowest unheld 0", 32'(diag_o), 32'hA);
        hold = 4'b0101;
        #1 check("R8 lowest unheld 1", 32'(diag_o), 32'(4'hA ^ 1));
        hold = 4'b1111;
        #1 check("R8 all held", 32'(diag_o), 0);
        hold = 4'b0000; g_bmp = 0;
        #1 check("R8 bitmap off", 32'(diag_o), 0);
    endtask

    task automatic t_disabled();
        @(negedge clk); g_inv = 1;
        @(negedge clk);
        check("R2 restart", 32'(inv_o), 32'b0011);
        test_en = 0; g_rst = 1; g_bmp = 1; hold = 4'b1010; fail_force = 4'b0100;
        #1 check("R9 invoke", 32'(inv_o), 0);
        check("R9 reset", 32'(rst_o), 0);
        check("R9 bitmap", 32'(bmp_o), 0);
        check("R9 hold", 32'(hold_o), 0);
        check("R9 fail", 32'(cfail_o), 0);
        check("R9 diag", 32'(diag_o), 0);
        check("R9 bank done", 32'(bdone_o), 0);
        g_rst = 0; g_bmp = 0; hold = '0; fail_force = '0; g_inv = 0;
        @(negedge clk); test_en = 1;
        #1 check("R9 seq idle", 32'(inv_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset_state();
        t_full_run();
        t_global_reset();
        t_fail_run();
        t_diag();
        t_disabled();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule